// File: doc/BRIEF.md
# Approximate OR-Merged Array Multiplier

This block multiplies two unsigned N-bit operands and returns a 2N-bit product that may fall slightly short of the exact value. It forms every partial-product bit with a two-input AND gate, as an exact multiplier does. The rows are then taken in pairs: row 2k and row 2k+1, selected by multiplier bits op_b[2k] and op_b[2k+1]. Across the lowest run of columns that both rows cover, each vertically aligned bit pair is replaced by the OR of the two bits. The bits that are not merged keep their weight. All surviving bits are sorted by column and stacked into as few rows as the tallest column needs. Those rows are summed with exact ripple-carry adders.

The merged run for each pair has a depth set per pair at elaboration. By default the depth shrinks by one for each pair going up, so the upper product bits come out exact or nearly exact, and only the low columns carry error. The block suits datapaths that tolerate a small one-sided error in exchange for a much shorter accumulation stage. An optional output register with an asynchronous active-low reset, released synchronously inside the block, gives one cycle of latency.

Top module: `amul_orclust_top`

## Requirements
- R1: When no merged column of any pair sees two ones, the product equals op_a*op_b exactly. This holds in particular when op_a has no two adjacent one bits, or when no pair of op_b bits (2k, 2k+1) is both one.
- R2: For pair k with effective depth L, columns 2k+1 up to 2k+L are merged. Each column c in that range where op_a[c-2k], op_a[c-2k-1], op_b[2k] and op_b[2k+1] are all one lowers the product by exactly 2^c compared with op_a*op_b. For example, with the default depths, 3*3 gives 7.
- R3: The product never exceeds op_a*op_b.
- R4: op_a*op_b minus the product never exceeds the sum of 2^c over every merged column c of every pair.
- R5: The depth of pair k is read from bits [6k+5:6k] of the DEPTHS parameter, and a value above N-1 acts as N-1. The default is N-1-k. A depth of 0 leaves that pair exact.
- R6: With REG_OUT=1, the product of the operands presented before a rising clock edge appears after that edge and is held until the next edge. While rst_n is low the product is zero.
- R7: A zero operand on either input gives a zero product.
- R8: For N=16 with default depths, 0x7895 times 0x0005 gives exactly 0x00025AE9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_a | input | N | Multiplicand, unsigned |
| op_b | input | N | Multiplier, unsigned; its bits select the row pairs |
| prod | output | 2N | Approximate product |

## Verification
The hardest case to reach from the ports is a collision deep in a high cluster. It needs two adjacent ones in op_a placed so that their merged column lands near the top of a pair's range, and it needs both op_b bits of that pair set at the same time. Uniform random operands rarely line up with only the top merged column of the highest pairs. The stimulus therefore includes directed patterns: 3*3 for the lowest column, all-ones for every column at once, and single-pair op_b values such as 0xC000. It also includes random operands made denser by OR-ing each value with a shifted copy of itself. A second instance with overridden depths (pair 0 exact, pair 1 clamped to full width) is driven with the same operands to expose the per-pair depth handling.

// File: rtl/amul_pkg.sv
`timescale 1ns/1ps
package amul_pkg;
  localparam int MAXP = 16;
  localparam int DW   = 6;
  typedef logic [MAXP*DW-1:0] depth_vec_t;

  // Default: pair k merges N-1-k columns.
  function automatic depth_vec_t default_depths(input int n);
    depth_vec_t v;
    v = '0;
    for (int k = 0; k < MAXP; k++) begin
      int d;
      d = (k < n/2) ? (n - 1 - k) : 0;
      v[k*DW +: DW] = d[DW-1:0];
    end
    return v;
  endfunction

  function automatic int eff_depth(input int n, input depth_vec_t dv, input int k);
    int d;
    d = int'(dv[k*DW +: DW]);
    return (d > n - 1) ? (n - 1) : d;
  endfunction

  function automatic bit has_main(input int n, input int k, input int c);
    return (c >= 2*k) && (c <= 2*k + n - 1);
  endfunction

  function automatic bit has_spill(input int n, input depth_vec_t dv, input int k, input int c);
    int l;
    l = eff_depth(n, dv, k);
    return (c == 2*k + n) || ((c >= 2*k + l + 1) && (c <= 2*k + n - 1));
  endfunction

  // Number of surviving bits in column c from pairs below k.
  function automatic int src_before(input int n, input depth_vec_t dv, input int c, input int k);
    int cnt;
    cnt = 0;
    for (int j = 0; j < k; j++) begin
      cnt += int'(has_main(n, j, c));
      cnt += int'(has_spill(n, dv, j, c));
    end
    return cnt;
  endfunction

  function automatic int slot_main(input int n, input depth_vec_t dv, input int c, input int k);
    return src_before(n, dv, c, k);
  endfunction

  function automatic int slot_spill(input int n, input depth_vec_t dv, input int c, input int k);
    return src_before(n, dv, c, k) + int'(has_main(n, k, c));
  endfunction

  function automatic int col_count(input int n, input depth_vec_t dv, input int c);
    return src_before(n, dv, c, n/2);
  endfunction

  function automatic int col_height(input int n, input depth_vec_t dv);
    int h;
    h = 1;
    for (int c = 0; c < 2*n; c++) begin
      if (col_count(n, dv, c) > h) h = col_count(n, dv, c);
    end
    return h;
  endfunction

  // Largest possible shortfall: every merged column collides once.
  function automatic logic [127:0] err_bound(input int n, input depth_vec_t dv);
    logic [127:0] s;
    s = '0;
    for (int k = 0; k < n/2; k++) begin
      for (int c = 2*k + 1; c <= 2*k + eff_depth(n, dv, k); c++) begin
        s += (128'(1) << c);
      end
    end
    return s;
  endfunction
endpackage

// File: rtl/amul_pair_merge.sv
`timescale 1ns/1ps
// Forms two partial-product rows and ORs their low overlapping columns.
module amul_pair_merge #(
  parameter int N = 16,
  parameter int K = 0,
  parameter int L = 15
) (
  input  logic [N-1:0]   a,
  input  logic           b_lo,
  input  logic           b_hi,
  output logic [2*N-1:0] main_row,
  output logic [2*N-1:0] spill_row
);
  localparam int W = 2 * N;

  for (genvar c = 0; c < W; c++) begin : g_col
    logic r0, r1;
    if (c >= 2*K && c <= 2*K + N - 1) begin : g_r0
      assign r0 = a[c-2*K] & b_lo;
    end else begin : g_r0z
      assign r0 = 1'b0;
    end
    if (c >= 2*K + 1 && c <= 2*K + N) begin : g_r1
      assign r1 = a[c-2*K-1] & b_hi;
    end else begin : g_r1z
      assign r1 = 1'b0;
    end
    if (c >= 2*K + 1 && c <= 2*K + L) begin : g_merge
      assign main_row[c]  = r0 | r1;
      assign spill_row[c] = 1'b0;
    end else begin : g_pass
      assign main_row[c]  = r0;
      assign spill_row[c] = r1;
    end
  end
endmodule

// File: rtl/amul_rca.sv
`timescale 1ns/1ps
// Exact ripple-carry adder, carry out dropped (sum fits by construction).
module amul_rca #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  logic [W-1:0] cy;
  assign cy[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i] = a[i] ^ b[i] ^ cy[i];
    if (i < W - 1) begin : g_cy
      assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
    end
  end
endmodule

// File: rtl/amul_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assert, synchronous release.
module amul_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_out = out_q;
endmodule

// File: rtl/amul_orclust_top.sv
`timescale 1ns/1ps
module amul_orclust_top #(
  parameter int                  N       = 16,
  parameter bit                  REG_OUT = 1'b1,
  parameter amul_pkg::depth_vec_t DEPTHS = amul_pkg::default_depths(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   op_a,
  input  logic [N-1:0]   op_b,
  output logic [2*N-1:0] prod
);
  localparam int NP = N / 2;
  localparam int W  = 2 * N;
  localparam int H  = amul_pkg::col_height(N, DEPTHS);

  logic [NP-1:0][W-1:0] m_rows;
  logic [NP-1:0][W-1:0] x_rows;
  logic [W*H-1:0]       grid;
  logic [W-1:0]         rows [H];
  logic [W-1:0]         acc  [H];
  logic [W-1:0]         prod_d;
  logic                 unused_rows;

  // Row pairs with OR merge
  for (genvar k = 0; k < NP; k++) begin : g_pair
    amul_pair_merge #(
      .N (N),
      .K (k),
      .L (amul_pkg::eff_depth(N, DEPTHS, k))
    ) u_pair (
      .a         (op_a),
      .b_lo      (op_b[2*k]),
      .b_hi      (op_b[2*k+1]),
      .main_row  (m_rows[k]),
      .spill_row (x_rows[k])
    );
  end

  // Regroup surviving bits by column weight into H rows
  for (genvar c = 0; c < W; c++) begin : g_col
    for (genvar k = 0; k < NP; k++) begin : g_src
      if (amul_pkg::has_main(N, k, c)) begin : g_m
        assign grid[c*H + amul_pkg::slot_main(N, DEPTHS, c, k)] = m_rows[k][c];
      end
      if (amul_pkg::has_spill(N, DEPTHS, k, c)) begin : g_x
        assign grid[c*H + amul_pkg::slot_spill(N, DEPTHS, c, k)] = x_rows[k][c];
      end
    end
    for (genvar s = 0; s < H; s++) begin : g_fill
      if (s >= amul_pkg::col_count(N, DEPTHS, c)) begin : g_z
        assign grid[c*H + s] = 1'b0;
      end
    end
  end

  always_comb begin
    for (int r = 0; r < H; r++) begin
      for (int c = 0; c < W; c++) begin
        rows[r][c] = grid[c*H + r];
      end
    end
  end

  // Exact accumulation
  assign acc[0] = rows[0];
  for (genvar r = 1; r < H; r++) begin : g_acc
    amul_rca #(.W(W)) u_add (
      .a   (acc[r-1]),
      .b   (rows[r]),
      .sum (acc[r])
    );
  end

  always_comb prod_d = acc[H-1];

  assign unused_rows = ^{m_rows, x_rows};

  // Optional output stage
  if (REG_OUT) begin : g_reg
    logic           rst_n_s;
    logic [W-1:0]   prod_q;

    amul_rst_sync u_rsync (
      .clk       (clk),
      .rst_n_in  (rst_n),
      .rst_n_out (rst_n_s)
    );

    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s) prod_q <= '0;
      else          prod_q <= prod_d;
    end

    assign prod = prod_q;
  end else begin : g_comb
    logic unused_clkrst;
    assign unused_clkrst = clk ^ rst_n;
    assign prod = prod_d;
  end
endmodule

module amul_orclust_chk #(
  parameter int                   N       = 16,
  parameter bit                   REG_OUT = 1'b1,
  parameter amul_pkg::depth_vec_t DEPTHS  = amul_pkg::default_depths(N)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   op_a,
  input logic [N-1:0]   op_b,
  input logic [2*N-1:0] prod
);
  localparam int             W       = 2 * N;
  localparam logic [W-1:0]   ERR_MAX = W'(amul_pkg::err_bound(N, DEPTHS));
  localparam logic [N-1:0]   EVEN    = {(N/2){2'b01}};

  logic [N-1:0] ca, cb;
  logic [1:0]   warm;
  logic [W-1:0] exact;
  logic         quiet;
  logic         no_collide;

  if (REG_OUT) begin : g_d
    always_ff @(posedge clk) begin
      ca <= op_a;
      cb <= op_b;
    end
  end else begin : g_c
    assign ca = op_a;
    assign cb = op_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             warm <= 2'd0;
    else if (warm != 2'd3)  warm <= warm + 2'd1;
  end

  assign exact      = W'(ca) * W'(cb);
  assign quiet      = !rst_n || (warm != 2'd3);
  assign no_collide = ((ca & (ca >> 1)) == '0) || ((cb & (cb >> 1) & EVEN) == '0);

  AST_NOT_ABOVE_EXACT: assert property (@(posedge clk) disable iff (quiet)
    prod <= exact); // R3

  AST_EXACT_WHEN_CLEAN: assert property (@(posedge clk) disable iff (quiet)
    no_collide |-> (prod == exact)); // R1

  AST_ERR_WITHIN_BOUND: assert property (@(posedge clk) disable iff (quiet)
    (exact - prod) <= ERR_MAX); // R4

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (quiet)
    ((ca == '0) || (cb == '0)) |-> (prod == '0)); // R7
endmodule

bind amul_orclust_top amul_orclust_chk #(
  .N       (N),
  .REG_OUT (REG_OUT),
  .DEPTHS  (DEPTHS)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .op_a  (op_a),
  .op_b  (op_b),
  .prod  (prod)
);

// File: tb/sim_amul_orclust_top.sv
`timescale 1ns/1ps
module sim_amul_orclust_top;
  localparam int N  = 16;
  localparam int NP = N / 2;
  localparam int W  = 2 * N;

  function automatic amul_pkg::depth_vec_t alt_depths();
    amul_pkg::depth_vec_t v;
    v = amul_pkg::default_depths(N);
    v[0 +: 6] = 6'd0;   // pair 0 exact
    v[6 +: 6] = 6'd63;  // pair 1 clamps to N-1
    return v;
  endfunction
  localparam amul_pkg::depth_vec_t ALT_D = alt_depths();

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] op_a, op_b;
  logic [W-1:0] p0, p1;
  int           n_cmp = 0;
  int           n_bad = 0;
  int           dep0 [NP];
  int           dep1 [NP];
  logic [W-1:0] exp0_q [$];
  logic [W-1:0] exp1_q [$];

  always #10 clk = ~clk;

  amul_orclust_top #(.N(N), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prod(p0));

  amul_orclust_top #(.N(N), .REG_OUT(1'b1), .DEPTHS(ALT_D)) u1 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prod(p1));

  // Behavioural model: exact product minus 2^c per colliding merged column.
  function automatic logic [W-1:0] model(input logic [N-1:0] a, input logic [N-1:0] b,
                                         input int dep [NP]);
    logic [W-1:0] e;
    e = W'(a) * W'(b);
    for (int k = 0; k < NP; k++) begin
      for (int j = 1; j <= dep[k]; j++) begin
        if (a[j] && a[j-1] && b[2*k] && b[2*k+1]) e = e - (W'(1) << (2*k + j));
      end
    end
    return e;
  endfunction

  function automatic logic [W-1:0] bound(input int dep [NP]);
    logic [W-1:0] s;
    s = '0;
    for (int k = 0; k < NP; k++)
      for (int j = 1; j <= dep[k]; j++) s = s + (W'(1) << (2*k + j));
    return s;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] expv);
    n_cmp++;
    if (got !== expv) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, expv);
    end
  endtask

  task automatic chk_le(input string req, input logic [W-1:0] got, input logic [W-1:0] lim);
    n_cmp++;
    if (got > lim) begin
      n_bad++;
      $display("FAIL %s: got %h expected <= %h", req, got, lim);
    end
  endtask

  // Drive at a falling edge, compare one full cycle later at the next falling edge.
  task automatic step(input logic [N-1:0] a, input logic [N-1:0] b, input string req);
    @(negedge clk);
    op_a = a;
    op_b = b;
    exp0_q.push_back(model(a, b, dep0));
    exp1_q.push_back(model(a, b, dep1));
    @(negedge clk);
    chk(req, p0, exp0_q.pop_front());
    chk("R5", p1, exp1_q.pop_front());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < NP; k++) begin
      dep0[k] = N - 1 - k;
      dep1[k] = N - 1 - k;
    end
    dep1[0] = 0;
    dep1[1] = N - 1;

    // R6: reset holds product at zero even with operands applied
    rst_n = 1'b0;
    op_a  = 16'hFFFF;
    op_b  = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk("R6", p0, '0);
    chk("R6", p1, '0);
    op_a = '0;
    op_b = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6", p0, '0);

    // R8: known vector, no collisions
    step(16'h7895, 16'h0005, "R8");
    chk("R8", p0, 32'h00025AE9);

    // R2: lowest merged column collides, 3*3 -> 7; u1 pair 0 exact -> 9
    step(16'h0003, 16'h0003, "R2");
    chk("R2", p0, 32'd7);
    chk("R5", p1, 32'd9);

    // R6: output holds until the next rising edge
    @(negedge clk);
    op_a = 16'h1234;
    op_b = 16'h0001;
    #3;
    chk("R6", p0, 32'd7);
    @(posedge clk);
    #3;
    chk("R6", p0, 32'h00001234);

    // R1: patterns that avoid collisions give exact products
    step(16'h5555, 16'hFFFF, "R1");
    chk("R1", p0, 32'(16'h5555) * 32'(16'hFFFF));
    step(16'hFFFF, 16'hAAAA, "R1");
    chk("R1", p0, 32'(16'hFFFF) * 32'(16'hAAAA));
    step(16'hFFFF, 16'h5555, "R1");
    chk("R1", p0, 32'(16'hFFFF) * 32'(16'h5555));

    // R7: zero operand
    step(16'h0000, 16'hFFFF, "R7");
    chk("R7", p0, '0);
    step(16'hFFFF, 16'h0000, "R7");
    chk("R7", p0, '0);

    // R2/R4: every merged column collides
    step(16'hFFFF, 16'hFFFF, "R2");
    chk_le("R4", 32'(16'hFFFF) * 32'(16'hFFFF) - p0, bound(dep0));
    // R5: single pairs, including clamped pair 1 and the highest pair
    step(16'hFFFF, 16'h000C, "R5");
    step(16'hFFFF, 16'hC000, "R2");
    step(16'h8001, 16'hC000, "R2");
    step(16'hC000, 16'h0003, "R2");

    // Random and densified random operands
    for (int i = 0; i < 400; i++) begin
      logic [N-1:0] a, b;
      logic [W-1:0] ex;
      a = N'($urandom);
      b = N'($urandom);
      if (i[0]) begin
        a = a | (a >> 1);
        b = b | (b >> 1);
      end
      step(a, b, "R2");
      ex = W'(a) * W'(b);
      chk_le("R3", p0, ex);
      chk_le("R4", ex - p0, bound(dep0));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule